// File: doc/BRIEF.md
# Interprocessor Interrupt Post Register

This block is one processor node's copy of a broadcast interrupt post register that sits on a shared system bus. Any processor or I/O node posts a nonvectored interrupt by writing a mask word to one fixed address. Every processor node holds its own copy of the register and accepts the same write, whatever receiver the write names. Each node has a fixed index. The bit of the mask at that index sets the node's pending flag, and the flag drives the interrupt line to the local processor.

The bus can only set the flag. A 1 bit sets the matching flag, and a 0 bit leaves it as it is. The local processor clears the flag through a separate port that uses write-one-to-clear. When a post and a clear reach the flag in the same cycle, the post wins, so no interrupt is lost. Reading the register over the bus is illegal: the block raises a one-cycle error flag and returns zero data.

Top module: `ipi_post_reg`

## Requirements
- R1: While synchronous reset `rst` is high, and in the first cycle after it falls, `irq` is 0 and `bus_err` is 0.
- R2: When `bus_wr` is high, `bus_addr` equals `REG_ADDR` and bit `NODE_ID` of `bus_wdata` is 1, `irq` is 1 from the next cycle on.
- R3: When a bus write to `REG_ADDR` carries 0 in bit `NODE_ID`, `irq` keeps its value, whether that value is 0 or 1. The other bits of the write data have no effect on `irq`.
- R4: A bus write to any address other than `REG_ADDR` leaves `irq` unchanged.
- R5: When `clr_we` is high and bit `NODE_ID` of `clr_wdata` is 1, `irq` is 0 in the next cycle, unless R7 applies. When `clr_we` is high and that bit is 0, `irq` is unchanged.
- R6: A bus read (`bus_rd` high) of `REG_ADDR` raises `bus_err` for exactly the next cycle, one pulse per read cycle. `bus_rdata` is always 0, and the read does not change `irq`.
- R7: When a bus post (R2) and a local clear (R5) both reach bit `NODE_ID` in the same cycle, the post wins and `irq` is 1 in the next cycle.
- R8: A bus read of any address other than `REG_ADDR` leaves `bus_err` at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | NODES | Bus write mask, one bit per node |
| bus_rdata | output | NODES | Read data, always zero |
| bus_err | output | 1 | Illegal-access flag, one cycle after a read of the register |
| clr_we | input | 1 | Local clear strobe |
| clr_wdata | input | NODES | Local clear mask, write-one-to-clear |
| irq | output | 1 | Pending interrupt to the local processor |

## Verification
The assertions take for granted that every strobe and address is a defined 0/1 value at each rising edge. They assume nothing about how the strobes combine: a read, a write and a clear may all arrive in the same cycle. The stimulus drives every input only at the falling edge and starts with reset high from time zero, so the properties never see values from before the first edge. It also hits the same-cycle cases on purpose: a post together with a clear, and a read together with a write.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;
  // Result of decoding one bus cycle against the register address
  typedef struct packed {
    logic post;  // legal broadcast write
    logic peek;  // illegal read
  } bus_hit_t;

  // Next state of a pending flag: a post takes priority over a clear
  function automatic logic next_pending(input logic cur, input logic set_i, input logic clr_i);
    if (set_i)      return 1'b1;
    else if (clr_i) return 1'b0;
    else            return cur;
  endfunction
endpackage

// File: rtl/ipi_addr_dec.sv
`timescale 1ns/1ps
module ipi_addr_dec #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output ipi_pkg::bus_hit_t hit
);
  logic addr_hit;
  assign addr_hit = (bus_addr == REG_ADDR);

  always_comb begin
    hit.post = bus_wr & addr_hit;
    hit.peek = bus_rd & addr_hit;
  end
endmodule

// File: rtl/ipi_pend_bit.sv
`timescale 1ns/1ps
module ipi_pend_bit #(
  parameter int NODES   = 8,
  parameter int NODE_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             post,
  input  logic [NODES-1:0] set_mask,
  input  logic             clr_we,
  input  logic [NODES-1:0] clr_mask,
  output logic             set_evt,
  output logic             clr_evt,
  output logic             pend
);
  localparam int SEL = NODE_ID % NODES;
  localparam logic [NODES-1:0] OWN_ONEHOT = NODES'(1) << SEL;

  // Pick this node's bit out of a mask word
  function automatic logic own_bit(input logic [NODES-1:0] vec);
    return |(vec & OWN_ONEHOT);
  endfunction

  assign set_evt = post & own_bit(set_mask);
  assign clr_evt = clr_we & own_bit(clr_mask);

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= ipi_pkg::next_pending(pend, set_evt, clr_evt);
  end
endmodule

// File: rtl/ipi_err_gen.sv
`timescale 1ns/1ps
module ipi_err_gen #(
  parameter int NODES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             peek,
  output logic             err,
  output logic [NODES-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= peek;
  end

  // The register cannot be read, so no data is ever returned
  assign rdata = '0;
endmodule

// File: rtl/ipi_post_reg.sv
`timescale 1ns/1ps
module ipi_post_reg #(
  parameter int NODES   = 8,
  parameter int NODE_ID = 3,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NODES-1:0]  bus_wdata,
  output logic [NODES-1:0]  bus_rdata,
  output logic              bus_err,
  input  logic              clr_we,
  input  logic [NODES-1:0]  clr_wdata,
  output logic              irq
);
  ipi_pkg::bus_hit_t hit;
  logic set_evt;
  logic clr_evt;

  ipi_addr_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .hit     (hit)
  );

  ipi_pend_bit #(.NODES(NODES), .NODE_ID(NODE_ID)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .post    (hit.post),
    .set_mask(bus_wdata),
    .clr_we  (clr_we),
    .clr_mask(clr_wdata),
    .set_evt (set_evt),
    .clr_evt (clr_evt),
    .pend    (irq)
  );

  ipi_err_gen #(.NODES(NODES)) u_err (
    .clk  (clk),
    .rst  (rst),
    .peek (hit.peek),
    .err  (bus_err),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/ipi_post_chk.sv
`timescale 1ns/1ps
module ipi_post_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              set_evt,
  input logic              clr_evt,
  input logic              irq,
  input logic              bus_err
);
  logic rd_here;
  assign rd_here = bus_rd && (bus_addr == REG_ADDR);

  p_set_r2: assert property (@(posedge clk) disable iff (rst) set_evt |=> irq);
  p_clr_r5: assert property (@(posedge clk) disable iff (rst) (clr_evt && !set_evt) |=> !irq);
  p_setwins_r7: assert property (@(posedge clk) disable iff (rst) (set_evt && clr_evt) |=> irq);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst) (!set_evt && !clr_evt) |=> $stable(irq));
  p_err_r6: assert property (@(posedge clk) disable iff (rst) rd_here |=> bus_err);
  p_noerr_r8: assert property (@(posedge clk) disable iff (rst) !rd_here |=> !bus_err);
endmodule

bind ipi_post_reg ipi_post_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .bus_rd (bus_rd),
  .bus_addr(bus_addr),
  .set_evt(set_evt),
  .clr_evt(clr_evt),
  .irq    (irq),
  .bus_err(bus_err)
);

// File: tb/test_ipi_post_reg.sv
`timescale 1ns/1ps
module test_ipi_post_reg;
  localparam int NODES = 8;
  localparam int ID = 3;
  localparam int AW = 12;
  localparam logic [AW-1:0] RA = 12'h040;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, clr_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NODES-1:0] bus_wdata = '0, clr_wdata = '0;
  logic [NODES-1:0] bus_rdata;
  logic bus_err, irq;

  int checks = 0;
  int errors = 0;
  int m_irq = 0;
  int m_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ipi_post_reg #(.NODES(NODES), .NODE_ID(ID), .ADDR_W(AW), .REG_ADDR(RA)) i_ipi_post_reg (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .clr_we(clr_we), .clr_wdata(clr_wdata), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at falling edge, update the model at the rising edge, compare at the next falling edge
  task automatic step(input bit r, input bit w, input bit rd, input int a, input int wd,
                      input bit cw, input int cd, input string tag);
    rst = r; bus_wr = w; bus_rd = rd; bus_addr = AW'(a);
    bus_wdata = NODES'(wd); clr_we = cw; clr_wdata = NODES'(cd);
    @(posedge clk);
    if (r) begin
      m_irq = 0; m_err = 0;
    end else begin
      bit posted  = w && (a == int'(RA)) && ((wd >> ID) & 1) == 1;
      bit cleared = cw && ((cd >> ID) & 1) == 1;
      m_err = (rd && a == int'(RA)) ? 1 : 0;
      if (posted) m_irq = 1;
      else if (cleared) m_irq = 0;
    end
    @(negedge clk);
    check({tag, " irq"}, int'(irq), m_irq);
    check({tag, " bus_err"}, int'(bus_err), m_err);
    check({tag, " rdata"}, int'(bus_rdata), 0);
  endtask

  initial begin
    @(negedge clk);
    step(1, 1, 1, 'h040, 'hFF, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    // R3: write with own bit zero, others set, from cleared state
    step(0, 1, 0, 'h040, 'hF7, 0, 0, "R3");
    // R4: own bit set but wrong address
    step(0, 1, 0, 'h041, 'h08, 0, 0, "R4");
    step(0, 1, 0, 'h840, 'hFF, 0, 0, "R4");
    // R2: legal post
    step(0, 1, 0, 'h040, 'h08, 0, 0, "R2");
    // R3: zero in own bit does not clear
    step(0, 1, 0, 'h040, 'h00, 0, 0, "R3");
    step(0, 1, 0, 'h040, 'hF7, 0, 0, "R3");
    // R5: clear with own bit zero has no effect, then with own bit one
    step(0, 0, 0, 0, 0, 1, 'hF7, "R5");
    step(0, 0, 0, 0, 0, 1, 'h08, "R5");
    step(0, 0, 0, 0, 0, 1, 'hFF, "R5");
    // R7: post and clear together, from 0 and from 1
    step(0, 1, 0, 'h040, 'h08, 1, 'h08, "R7");
    step(0, 1, 0, 'h040, 'hFF, 1, 'hFF, "R7");
    // R6: illegal reads, back to back, irq kept
    step(0, 0, 1, 'h040, 0, 0, 0, "R6");
    step(0, 0, 1, 'h040, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R6");
    // R8: read of another address
    step(0, 0, 1, 'h044, 0, 0, 0, "R8");
    // R6 with a write and a clear in the same cycle
    step(0, 1, 1, 'h040, 'h00, 1, 'h08, "R6");
    step(0, 1, 1, 'h040, 'h08, 0, 0, "R6");
    // R1: reset in the middle of activity
    step(1, 1, 1, 'h040, 'h08, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    // sweep of mask patterns
    for (int k = 0; k < 64; k++) begin
      step(0, k[0], k[1], (k[2] ? 'h040 : 'h041), (k * 37) & 'hFF, k[3], (k * 11) & 'hFF, "R2");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule